// File: doc/BRIEF.md
# Codirectional 64 kbit/s Line Receiver with Time-Slot Readout

This block takes a codirectional 64 kbit/s line signal as two active-low rails and a 128 kHz clock recovered from that line. It decodes the two-sample bit code back into data bits. It finds octet boundaries from the deliberate same-rail marking that closes every octet. Complete octets go into a pair of alternating storage registers. On the local side, each octet is sent as an 8-bit burst on a serial PCM output, timed by the 2.048 MHz local clock, while the selected time-slot envelope is high.

All inputs are asynchronous to the system clock `clk`. Each input is resynchronised, and both line clocks are reduced to single-cycle rising-edge events. Write and read rates differ slightly, so the store handles the mismatch in whole octets. When no new octet has arrived since the last burst, that octet is sent again. When the writer runs ahead, the oldest unread octet is overwritten. The line and slot pins are plain levels with no handshake, so the block has no back-pressure of any kind.

Top module: `codir_rx`

## Requirements
- R1: The rails are active low. A sample is a mark when either rail is low and a space when both are high. Samples are taken on rising edges of `rec_clk`. Each bit is two samples: (space, mark) decodes to 0 and (mark, mark) decodes to 1, so the first sample carries the value.
- R2: A mark on the same rail as the preceding mark is an octet boundary, and it is the second sample of the octet's eighth bit. Marks on alternating rails are never boundaries. If both rails are low at once, the sample counts as a positive-rail mark.
- R3: `octet_aligned` rises when a boundary arrives exactly 16 samples after the previous boundary.
- R4: While aligned, one octet period that ends without a boundary leaves `octet_aligned` high. A second consecutive such period drops it.
- R5: While aligned, a same-rail mark at any other position is ignored. Decoding and octet phase are unchanged.
- R6: While not aligned, a boundary restarts the octet phase, so the next sample is the first sample of bit 1.
- R7: An octet is stored at the end of each octet period in which the receiver is, or becomes, aligned. The first decoded bit of the octet is the first bit sent in a burst (MSB first).
- R8: On the first rising edge of `loc_clk` with the selected envelope high, the burst starts. The first bit appears on `pcm_out`, and the remaining seven bits follow on the next seven edges. `pcm_act` is high only while one of these eight bits is on `pcm_out`. At all other times `pcm_out` is high.
- R9: When `slot_sel` is high, `slot_a` is selected; when it is low, `slot_b` is selected. The unselected envelope produces no burst and consumes no octet.
- R10: A burst that finds no octet stored since the previous burst repeats the previous octet. Before any octet has been stored, the burst is all ones.
- R11: When both registers hold unread octets and another octet arrives, the oldest unread one is overwritten. Bursts always deliver the oldest remaining octet first.
- R12: After reset, `pcm_out` is 1, `pcm_act` is 0 and `octet_aligned` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all other inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_pos_n | input | 1 | Positive line rail, active low |
| line_neg_n | input | 1 | Negative line rail, active low |
| rec_clk | input | 1 | 128 kHz clock recovered from the line |
| loc_clk | input | 1 | 2.048 MHz local readout clock |
| slot_a | input | 1 | First time-slot envelope |
| slot_b | input | 1 | Second time-slot envelope |
| slot_sel | input | 1 | Envelope select: 1 picks `slot_a`, 0 picks `slot_b` |
| pcm_out | output | 1 | Serial PCM burst output, idle high |
| pcm_act | output | 1 | High while a burst bit is on `pcm_out` |
| octet_aligned | output | 1 | Octet boundary lock indicator |

## Verification
Every pin passes through a two-flop resynchroniser and one edge flop. As a result, decoder state, `octet_aligned` and `pcm_out` change on the third `clk` edge after the pin edge that caused the change. The bench holds rails and envelopes stable for four cycles before each clock edge it drives. It reads `pcm_out` and `pcm_act` six cycles after each `loc_clk` rise, and it reads `octet_aligned` twelve cycles after the last sample of an octet. That timing puts every sample well past the due cycle and before the next driven edge.

// File: rtl/codir_rx_pkg.sv
package codir_rx_pkg;

  // Rail identity of a line mark.
  typedef enum logic {
    RAIL_POS = 1'b0,
    RAIL_NEG = 1'b1
  } rail_e;

  // Decoded view of one line sample.
  typedef struct packed {
    logic  mark;
    rail_e rail;
  } line_samp_t;

  // Active-low rails to sample; a positive mark wins when both are low.
  function automatic line_samp_t decode_rails(input logic pos_n, input logic neg_n);
    line_samp_t s;
    s.mark = !pos_n || !neg_n;
    s.rail = pos_n ? RAIL_NEG : RAIL_POS;
    return s;
  endfunction

endpackage

// File: rtl/codir_sync.sv
module codir_sync #(
  parameter int          W      = 1,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST_V = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[g] <= RST_V;
          else        stg_q[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[g] <= RST_V;
          else        stg_q[g] <= stg_q[g-1];
        end
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/codir_decoder.sv
module codir_decoder
  import codir_rx_pkg::*;
#(
  parameter int OCT_W      = 8,
  parameter int LOCK_HITS  = 2,
  parameter int LOSS_LIMIT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             samp_evt,
  input  logic             pos_n,
  input  logic             neg_n,
  output logic             wr_en,
  output logic [OCT_W-1:0] wr_data,
  output logic             aligned
);

  localparam int SAMP = 2 * OCT_W;
  localparam int CW   = $clog2(SAMP);
  localparam int HW   = $clog2(LOCK_HITS + 1);
  localparam int MW   = $clog2(LOSS_LIMIT + 1);

  logic [CW-1:0]    cnt_q, cnt_d;
  logic             first_q;
  logic [OCT_W-2:0] sh_q;
  logic             have_q;
  rail_e            rail_q;
  logic [HW-1:0]    hit_q, hit_d, hit_inc;
  logic [MW-1:0]    miss_q, miss_d;
  logic             aligned_q, aligned_d;
  line_samp_t       smp;
  logic             viol, at_end;

  always_comb begin
    smp     = decode_rails(pos_n, neg_n);
    viol    = smp.mark && have_q && (smp.rail == rail_q);
    at_end  = (cnt_q == CW'(SAMP - 1));
    hit_inc = (hit_q == HW'(LOCK_HITS)) ? hit_q : hit_q + 1'b1;

    aligned_d = aligned_q;
    hit_d     = hit_q;
    miss_d    = miss_q;
    cnt_d     = (at_end || (viol && !aligned_q)) ? '0 : cnt_q + 1'b1;

    if (aligned_q) begin
      if (at_end) begin
        if (viol) begin
          miss_d = '0;
        end else if (miss_q == MW'(LOSS_LIMIT - 1)) begin
          aligned_d = 1'b0;
          hit_d     = '0;
          miss_d    = '0;
        end else begin
          miss_d = miss_q + 1'b1;
        end
      end
    end else if (viol) begin
      hit_d = (at_end && hit_q != '0) ? hit_inc : HW'(1);
      if (hit_d == HW'(LOCK_HITS)) begin
        aligned_d = 1'b1;
        miss_d    = '0;
      end
    end else if (at_end) begin
      hit_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      first_q   <= 1'b0;
      sh_q      <= '0;
      have_q    <= 1'b0;
      rail_q    <= RAIL_POS;
      hit_q     <= '0;
      miss_q    <= '0;
      aligned_q <= 1'b0;
    end else if (samp_evt) begin
      cnt_q     <= cnt_d;
      hit_q     <= hit_d;
      miss_q    <= miss_d;
      aligned_q <= aligned_d;
      if (smp.mark) begin
        have_q <= 1'b1;
        rail_q <= smp.rail;
      end
      if (!cnt_q[0]) first_q <= smp.mark;
      else           sh_q    <= {sh_q[OCT_W-3:0], first_q};
    end
  end

  assign wr_en   = samp_evt && at_end && aligned_d;
  assign wr_data = {sh_q, first_q};
  assign aligned = aligned_q;

  AST_LOCK_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aligned_q) |-> $past(samp_evt && viol)); // R3
  AST_LOSS_AT_OCTET_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(aligned_q) |-> $past(samp_evt && at_end && !viol)); // R4
  AST_STORE_WHILE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> aligned_q); // R7
  AST_STRAY_KEEPS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_evt && aligned_q && viol && !at_end) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R5

endmodule

// File: rtl/codir_octet_buf.sv
module codir_octet_buf #(
  parameter int OCT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OCT_W-1:0] wr_data,
  input  logic             rd_req,
  output logic [OCT_W-1:0] rd_data
);

  localparam int NREG = 2;

  logic [NREG-1:0][OCT_W-1:0] mem_q;
  logic [NREG-1:0]            full_q;
  logic                       newest_q;
  logic                       last_q;
  logic                       pick;
  logic                       wtgt;

  always_comb begin
    wtgt = !newest_q;
    if (full_q[!newest_q])    pick = !newest_q;
    else if (full_q[newest_q]) pick = newest_q;
    else                       pick = last_q;
    rd_data = mem_q[pick];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q    <= '1;
      full_q   <= '0;
      newest_q <= 1'b1;
      last_q   <= 1'b0;
    end else begin
      if (rd_req) begin
        full_q[pick] <= 1'b0;
        last_q       <= pick;
      end
      if (wr_en) begin
        mem_q[wtgt]  <= wr_data;
        full_q[wtgt] <= 1'b1;
        newest_q     <= wtgt;
      end
    end
  end

  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> full_q[newest_q]); // R11
  AST_REPEAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !wr_en && full_q == '0) |=> (full_q == '0) && $stable(last_q)); // R10
  AST_OLDEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && full_q == '1) |=> (last_q == $past(!newest_q))); // R11

endmodule

// File: rtl/codir_slot_out.sv
module codir_slot_out #(
  parameter int OCT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_evt,
  input  logic             slot_on,
  input  logic [OCT_W-1:0] rd_data,
  output logic             rd_req,
  output logic             pcm_out,
  output logic             pcm_act
);

  localparam int BW = $clog2(OCT_W + 1);

  logic [BW-1:0]    bcnt_q;
  logic [OCT_W-1:0] burst_q;
  logic             out_q, act_q;

  assign rd_req = bit_evt && slot_on && (bcnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q  <= '0;
      burst_q <= '1;
      out_q   <= 1'b1;
      act_q   <= 1'b0;
    end else if (bit_evt) begin
      if (!slot_on) begin
        bcnt_q <= '0;
        out_q  <= 1'b1;
        act_q  <= 1'b0;
      end else if (bcnt_q == '0) begin
        burst_q <= rd_data << 1;
        out_q   <= rd_data[OCT_W-1];
        act_q   <= 1'b1;
        bcnt_q  <= BW'(1);
      end else if (bcnt_q < BW'(OCT_W)) begin
        burst_q <= burst_q << 1;
        out_q   <= burst_q[OCT_W-1];
        bcnt_q  <= bcnt_q + 1'b1;
      end else begin
        out_q <= 1'b1;
        act_q <= 1'b0;
      end
    end
  end

  assign pcm_out = out_q;
  assign pcm_act = act_q;

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !pcm_act |-> pcm_out); // R8
  AST_BURST_STARTS_WITH_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pcm_act) |-> $past(rd_req)); // R8
  AST_ACT_NEEDS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_evt && !slot_on) |=> !pcm_act); // R9

endmodule

// File: rtl/codir_rx.sv
module codir_rx #(
  parameter int OCT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_HITS   = 2,
  parameter int LOSS_LIMIT  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_pos_n,
  input  logic line_neg_n,
  input  logic rec_clk,
  input  logic loc_clk,
  input  logic slot_a,
  input  logic slot_b,
  input  logic slot_sel,
  output logic pcm_out,
  output logic pcm_act,
  output logic octet_aligned
);

  localparam int NIN = 7;

  logic [NIN-1:0] pins, pins_s;
  logic           pos_s, neg_s, rclk_s, lclk_s, sa_s, sb_s, sel_s;
  logic           rclk_d, lclk_d;
  logic           samp_evt, bit_evt, slot_on;
  logic             wr_en, rd_req;
  logic [OCT_W-1:0] wr_data, rd_data;

  assign pins = {line_pos_n, line_neg_n, rec_clk, loc_clk, slot_a, slot_b, slot_sel};

  codir_sync #(
    .W      (NIN),
    .STAGES (SYNC_STAGES),
    .RST_V  (7'b1100000)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pins),
    .q     (pins_s)
  );

  assign {pos_s, neg_s, rclk_s, lclk_s, sa_s, sb_s, sel_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rclk_d <= 1'b0;
      lclk_d <= 1'b0;
    end else begin
      rclk_d <= rclk_s;
      lclk_d <= lclk_s;
    end
  end

  assign samp_evt = rclk_s && !rclk_d;
  assign bit_evt  = lclk_s && !lclk_d;
  assign slot_on  = sel_s ? sa_s : sb_s;

  codir_decoder #(
    .OCT_W      (OCT_W),
    .LOCK_HITS  (LOCK_HITS),
    .LOSS_LIMIT (LOSS_LIMIT)
  ) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .samp_evt (samp_evt),
    .pos_n    (pos_s),
    .neg_n    (neg_s),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .aligned  (octet_aligned)
  );

  codir_octet_buf #(
    .OCT_W (OCT_W)
  ) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_req  (rd_req),
    .rd_data (rd_data)
  );

  codir_slot_out #(
    .OCT_W (OCT_W)
  ) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_evt (bit_evt),
    .slot_on (slot_on),
    .rd_data (rd_data),
    .rd_req  (rd_req),
    .pcm_out (pcm_out),
    .pcm_act (pcm_act)
  );

endmodule

// File: tb/codir_rx_test.sv
module codir_rx_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_pos_n = 1'b1, line_neg_n = 1'b1;
  logic rec_clk = 1'b0, loc_clk = 1'b0;
  logic slot_a = 1'b0, slot_b = 1'b0, slot_sel = 1'b1;
  logic pcm_out, pcm_act, octet_aligned;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic pol   = 1'b0;

  always #10 clk = ~clk;

  codir_rx uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .line_pos_n    (line_pos_n),
    .line_neg_n    (line_neg_n),
    .rec_clk       (rec_clk),
    .loc_clk       (loc_clk),
    .slot_a        (slot_a),
    .slot_b        (slot_b),
    .slot_sel      (slot_sel),
    .pcm_out       (pcm_out),
    .pcm_act       (pcm_act),
    .octet_aligned (octet_aligned)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // One 128 kHz sample: rails settle, then a rising recovered-clock edge.
  task automatic send_sample(input logic mark, input logic rail);
    line_pos_n = !(mark && rail == 1'b0);
    line_neg_n = !(mark && rail == 1'b1);
    tick(4);
    rec_clk = 1'b1;
    tick(8);
    rec_clk = 1'b0;
    tick(4);
  endtask

  // Octet MSB first; bnd closes it with a same-rail mark, stray adds one mid-octet.
  task automatic send_octet(input logic [7:0] d, input bit bnd, input bit stray);
    for (int i = 0; i < 8; i++) begin
      if (d[7-i]) begin
        pol = ~pol;
        send_sample(1'b1, pol);
      end else begin
        send_sample(1'b0, 1'b0);
      end
      if (!((bnd && i == 7) || (stray && i == 3))) pol = ~pol;
      send_sample(1'b1, pol);
    end
  endtask

  // One time-slot burst on the chosen envelope, checked against exp.
  task automatic read_slot(input logic sel, input bit use_a, input logic [7:0] exp, input string tag);
    logic [7:0] got = '0;
    logic act_ok = 1'b1;
    slot_sel = sel;
    if (use_a) slot_a = 1'b1; else slot_b = 1'b1;
    for (int k = 0; k < 9; k++) begin
      loc_clk = 1'b0;
      tick(8);
      loc_clk = 1'b1;
      tick(6);
      if (k < 8) begin
        got = {got[6:0], pcm_out};
        if (!pcm_act) act_ok = 1'b0;
      end else begin
        check({tag, " idle after burst R8"}, {30'd0, pcm_act, pcm_out}, 32'h1);
      end
      tick(2);
    end
    check({tag, " burst data"}, {24'd0, got}, {24'd0, exp});
    check({tag, " pcm_act during burst R8"}, {31'd0, act_ok}, 32'h1);
    slot_a = 1'b0;
    slot_b = 1'b0;
    loc_clk = 1'b0;
    tick(8);
    loc_clk = 1'b1;
    tick(8);
    loc_clk = 1'b0;
    tick(4);
  endtask

  task automatic t_reset;
    check("R12 pcm_out after reset", {31'd0, pcm_out}, 32'h1);
    check("R12 pcm_act after reset", {31'd0, pcm_act}, 32'h0);
    check("R12 aligned after reset", {31'd0, octet_aligned}, 32'h0);
  endtask

  task automatic t_empty_read;
    read_slot(1'b1, 1'b1, 8'hFF, "R10 burst before any octet");
  endtask

  task automatic t_lock;
    send_octet(8'h3C, 1'b1, 1'b0);
    tick(8);
    check("R3 one boundary does not lock", {31'd0, octet_aligned}, 32'h0);
    send_octet(8'hA6, 1'b1, 1'b0);
    tick(8);
    check("R2 R3 lock after two boundaries", {31'd0, octet_aligned}, 32'h1);
    read_slot(1'b1, 1'b1, 8'hA6, "R1 R7 decoded octet MSB first");
    read_slot(1'b1, 1'b1, 8'hA6, "R10 repeat when nothing new");
  endtask

  task automatic t_delete;
    send_octet(8'h11, 1'b1, 1'b0);
    send_octet(8'hC3, 1'b1, 1'b0);
    send_octet(8'h5E, 1'b1, 1'b0);
    read_slot(1'b1, 1'b1, 8'hC3, "R11 oldest survivor first");
    read_slot(1'b1, 1'b1, 8'h5E, "R11 newest next");
  endtask

  task automatic t_select;
    logic seen = 1'b0;
    send_octet(8'h81, 1'b1, 1'b0);
    slot_sel = 1'b1;
    slot_b = 1'b1;
    for (int k = 0; k < 10; k++) begin
      loc_clk = 1'b0;
      tick(8);
      loc_clk = 1'b1;
      tick(6);
      if (pcm_act || !pcm_out) seen = 1'b1;
      tick(2);
    end
    slot_b = 1'b0;
    loc_clk = 1'b0;
    tick(8);
    check("R9 unselected envelope ignored", {31'd0, seen}, 32'h0);
    read_slot(1'b0, 1'b0, 8'h81, "R9 slot_b selected, octet kept");
  endtask

  task automatic t_loss;
    send_octet(8'h6D, 1'b0, 1'b0);
    tick(8);
    check("R4 one miss keeps lock", {31'd0, octet_aligned}, 32'h1);
    send_octet(8'h24, 1'b0, 1'b0);
    tick(8);
    check("R4 two misses drop lock", {31'd0, octet_aligned}, 32'h0);
    read_slot(1'b1, 1'b1, 8'h6D, "R4 R7 stored before loss only");
  endtask

  task automatic t_relock;
    send_sample(1'b0, 1'b0);
    send_sample(1'b0, 1'b0);
    send_sample(1'b0, 1'b0);
    send_octet(8'hF0, 1'b1, 1'b0);
    tick(8);
    check("R6 resync boundary alone", {31'd0, octet_aligned}, 32'h0);
    send_octet(8'h9B, 1'b1, 1'b0);
    tick(8);
    check("R6 relock at new phase", {31'd0, octet_aligned}, 32'h1);
    send_octet(8'h47, 1'b1, 1'b1);
    tick(8);
    check("R5 stray same-rail mark keeps lock", {31'd0, octet_aligned}, 32'h1);
    read_slot(1'b1, 1'b1, 8'h9B, "R6 octet at new phase");
    read_slot(1'b1, 1'b1, 8'h47, "R5 octet with stray mark intact");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_empty_read();
    t_lock();
    t_delete();
    t_select();
    t_loss();
    t_relock();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule